// File: doc/BRIEF.md
# Flash Device Mode and Reset Controller

This block is the control core of a parallel NOR-style flash device. It watches the chip-enable, output-enable and write-enable strobes, the active-low device reset pin and a busy flag from the internal program/erase engine. From these it works out the device operating mode. It decides when the data bus drivers may be on, and it times the two recovery windows that follow a reset. It also loads the status, configuration and read-mode registers with their reset values, and it aborts a program or erase that a reset interrupts.

Reset is sampled on the clock. While the pin is low the block holds everything in its reset mode and keeps the bus high-impedance. When the pin is released, one counter starts at the first clock edge. It opens the output-valid window after `T_OV` edges and the write window after `T_WE` edges. Write strobes that complete before the write window opens are dropped, and a sticky flag records them.

The engine is modelled only by its handshake. The block raises an abort request as soon as reset meets a busy engine. It passes accepted write strobes to the command layer, which is outside this block, as one-cycle pulses.

Top module: `flash_mode_ctrl`

## Requirements
- R1: `dq_oe` is 1 only while `rst_n`=1, `ce_n`=0, `oe_n`=0 and the output-valid window is open. With `ce_n`=1 it is 0 whatever `oe_n` is.
- R2: While `rst_n`=0, `dq_oe` is 0 in the same cycle, and from the first reset edge `mode_oh` reads 5'b00001 (RESET).
- R3: Counting clock edges from reset release, `dq_oe` can first be 1 after edge `T_OV` (default 150) and is still 0 after edge `T_OV`-1.
- R4: A write strobe is a rising `we_n` while `ce_n`=0, judged at a clock edge.
  - A strobe judged at edge `T_WE` (default 200) or earlier is ignored: no `wr_accept`, and `wr_rej` becomes 1.
  - A strobe judged at edge `T_WE`+1 or later gives a `wr_accept` pulse of one cycle after that edge.
- R5: After reset, `sts` is 8'h80, `rd_mode` is 2'd0 (read-array) and `cfg` equals `CFG_RST`. The default is all zeros, meaning asynchronous page-mode reads.
- R6: `eng_abort` is 1 in any cycle with `rst_n`=0 and `eng_busy`=1. Such a reset sets `sts` bit 5 (contents invalid), so `sts` reads 8'hA0 once reset is released. The bit clears on the edge after an accepted write, and any reset that aborts nothing also clears it.
- R7: `sts` bit 7 is the inverse of `eng_busy` in the same cycle (1 = idle, 0 = busy).
- R8: While `eng_busy`=1 the mode is ACTIVE_BUSY (5'b10000) and `active_pwr`=1, even with `ce_n`=1. On the first edge after busy drops, the mode follows `ce_n`.
- R9: `mode_oh` is one-hot: bit0 RESET, bit1 WAKEUP, bit2 STANDBY, bit3 ACTIVE_IDLE, bit4 ACTIVE_BUSY.
  - WAKEUP lasts from edge 1 through edge `T_WE`-1 after release.
  - After that the mode is STANDBY when `ce_n`=1, or ACTIVE_IDLE when `ce_n`=0, while the engine is idle.
  - `active_pwr` is 1 only in the two ACTIVE modes.
- R10: `wr_rej` stays 1 once set, through later accepted writes, until the next reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low device reset pin, sampled on `clk` |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| eng_busy | input | 1 | Program/erase engine is running |
| dq_oe | output | 1 | Data bus driver enable (0 = high-impedance) |
| wr_accept | output | 1 | One-cycle pulse for an accepted write strobe |
| wr_rej | output | 1 | Sticky: a write strobe came before the write window |
| eng_abort | output | 1 | Abort request to the engine |
| active_pwr | output | 1 | Device is drawing active power |
| mode_oh | output | 5 | One-hot operating mode |
| sts | output | STS_W | Status register |
| cfg | output | CFG_W | Configuration register |
| rd_mode | output | 2 | Read mode, 0 = read-array |

## Verification
Two pairs of events can land on the same clock edge:
- a write strobe and the opening of the write window;
- an asserted reset and a running engine.

The bench places a strobe exactly at edge 200 and, after a fresh reset, exactly at edge 201. It expects the first to be rejected and the second to be accepted without a rejection. It also asserts reset while the engine is busy, expects the abort request in that same cycle, and expects status 8'hA0 after wake-up, falling back to 8'h80 only after the next accepted write.

// File: rtl/flash_mode_pkg.sv
`timescale 1ns/1ps
package flash_mode_pkg;
   typedef enum logic [4:0] {
      M_RESET = 5'b00001,
      M_WAKE  = 5'b00010,
      M_STBY  = 5'b00100,
      M_IDLE  = 5'b01000,
      M_BUSY  = 5'b10000
   } mode_e;

   typedef enum logic [1:0] {
      RD_ARRAY  = 2'd0,
      RD_STATUS = 2'd1,
      RD_IDENT  = 2'd2,
      RD_QUERY  = 2'd3
   } rdmode_e;

   localparam int STS_RDY_BIT = 7;
   localparam int STS_ABT_BIT = 5;
endpackage

// File: rtl/fm_wake_timer.sv
`timescale 1ns/1ps
module fm_wake_timer #(
   parameter int T_OV = 150,
   parameter int T_WE = 200,
   localparam int CW = $clog2(T_WE + 1)
) (
   input  logic clk,
   input  logic rst_n,
   output logic ov_ok,
   output logic wr_ok,
   output logic wr_ok_nxt
);
   if (T_WE < 2) begin : g_bad_we
      $error("T_WE must be at least 2");
   end
   if (T_OV < 1 || T_OV > T_WE) begin : g_bad_ov
      $error("T_OV must lie in 1..T_WE");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!wr_ok) cnt_q <= cnt_q + 1'b1;
   end

   assign ov_ok     = (cnt_q >= CW'(T_OV));
   assign wr_ok     = (cnt_q >= CW'(T_WE));
   assign wr_ok_nxt = (cnt_q >= CW'(T_WE - 1));

   // R3: once the write window is open it stays open until reset
   p_we_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |=> wr_ok);
   // R3: output-valid window never opens later than the write window
   p_ov_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |-> ov_ok);
endmodule

// File: rtl/fm_wr_gate.sv
`timescale 1ns/1ps
module fm_wr_gate #(
   parameter bit WR_ON_RISE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic we_n,
   input  logic wr_ok,
   output logic wr_accept,
   output logic wr_rej
);
   logic we_q;
   logic strobe;

   always_ff @(posedge clk) begin
      if (!rst_n) we_q <= 1'b1;
      else        we_q <= we_n;
   end

   if (WR_ON_RISE) begin : g_rise
      assign strobe = ~we_q & we_n & ~ce_n;
   end else begin : g_fall
      assign strobe = we_q & ~we_n & ~ce_n;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_accept <= 1'b0;
         wr_rej    <= 1'b0;
      end else begin
         wr_accept <= strobe & wr_ok;
         if (strobe & ~wr_ok) wr_rej <= 1'b1;
      end
   end

   // R4: an accepted write implies the window was open at the strobe edge
   p_acc_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_accept |-> $past(wr_ok));
   // R10: rejection flag is sticky outside reset
   p_rej_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rej |=> wr_rej);
endmodule

// File: rtl/fm_mode_fsm.sv
`timescale 1ns/1ps
module fm_mode_fsm
   import flash_mode_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  ce_n,
   input  logic  eng_busy,
   input  logic  wr_ok_nxt,
   input  logic  wr_accept,
   output mode_e mode,
   output logic  abort_flg
);
   mode_e run_sel;

   always_comb begin
      if (eng_busy)   run_sel = M_BUSY;
      else if (!ce_n) run_sel = M_IDLE;
      else            run_sel = M_STBY;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          mode <= M_RESET;
      else if (!wr_ok_nxt) mode <= M_WAKE;
      else                 mode <= run_sel;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         if (eng_busy || mode == M_BUSY) abort_flg <= 1'b1;
         else if (mode == M_RESET)       abort_flg <= abort_flg;
         else                            abort_flg <= 1'b0;
      end else if (wr_accept) begin
         abort_flg <= 1'b0;
      end
   end

   // R9: exactly one mode bit outside reset
   p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mode) == 1);
   // R8: deselect does not end a running operation
   p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_BUSY && eng_busy) |=> (mode == M_BUSY));
   // R6: reset meeting a busy engine marks the contents invalid
   p_abort_mark_r6: assert property (@(posedge clk)
      (!rst_n && eng_busy) |=> abort_flg);
endmodule

// File: rtl/flash_mode_ctrl.sv
`timescale 1ns/1ps
module flash_mode_ctrl
   import flash_mode_pkg::*;
#(
   parameter int             T_OV       = 150,
   parameter int             T_WE       = 200,
   parameter int             STS_W      = 8,
   parameter int             CFG_W      = 16,
   parameter logic [CFG_W-1:0] CFG_RST  = '0,
   parameter bit             WR_ON_RISE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce_n,
   input  logic             oe_n,
   input  logic             we_n,
   input  logic             eng_busy,
   output logic             dq_oe,
   output logic             wr_accept,
   output logic             wr_rej,
   output logic             eng_abort,
   output logic             active_pwr,
   output logic [4:0]       mode_oh,
   output logic [STS_W-1:0] sts,
   output logic [CFG_W-1:0] cfg,
   output logic [1:0]       rd_mode
);
   if (STS_W < 8) begin : g_bad_sts
      $error("STS_W must be at least 8");
   end

   logic    ov_ok, wr_ok, wr_ok_nxt, abort_flg;
   mode_e   mode;
   rdmode_e rd_q;

   fm_wake_timer #(.T_OV(T_OV), .T_WE(T_WE)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .ov_ok(ov_ok), .wr_ok(wr_ok), .wr_ok_nxt(wr_ok_nxt));

   fm_wr_gate #(.WR_ON_RISE(WR_ON_RISE)) u_gate (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
      .wr_ok(wr_ok), .wr_accept(wr_accept), .wr_rej(wr_rej));

   fm_mode_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .eng_busy(eng_busy),
      .wr_ok_nxt(wr_ok_nxt), .wr_accept(wr_accept),
      .mode(mode), .abort_flg(abort_flg));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg  <= CFG_RST;
         rd_q <= RD_ARRAY;
      end
   end

   always_comb begin
      sts              = '0;
      sts[STS_RDY_BIT] = ~eng_busy;
      sts[STS_ABT_BIT] = abort_flg;
   end

   assign rd_mode    = rd_q;
   assign mode_oh    = mode;
   assign dq_oe      = rst_n & ~ce_n & ~oe_n & ov_ok;
   assign eng_abort  = ~rst_n & eng_busy;
   assign active_pwr = (mode == M_IDLE) || (mode == M_BUSY);

   // R1: deselected device never drives the bus
   p_desel_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |-> !dq_oe);
   // R1: no drive while the wake-up state is still earlier than output-valid
   p_wake_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_WAKE && !ov_ok) |-> !dq_oe);
   // R5: register defaults follow every reset edge
   p_defaults_r5: assert property (@(posedge clk)
      !rst_n |=> (cfg == CFG_RST && rd_mode == 2'd0));
endmodule

// File: tb/flash_mode_ctrl_bench.sv
`timescale 1ns/1ps
module flash_mode_ctrl_bench;
   localparam int T_OV = 150;
   localparam int T_WE = 200;

   logic clk = 1'b0;
   logic rst_n = 1'b0, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, eng_busy = 1'b0;
   logic dq_oe, wr_accept, wr_rej, eng_abort, active_pwr;
   logic [4:0]  mode_oh;
   logic [7:0]  sts;
   logic [15:0] cfg;
   logic [1:0]  rd_mode;

   int checks = 0, fails = 0, ec = 0, acc_cnt = 0;

   always #4 clk = ~clk;

   flash_mode_ctrl u_flash_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .eng_busy(eng_busy), .dq_oe(dq_oe), .wr_accept(wr_accept),
      .wr_rej(wr_rej), .eng_abort(eng_abort), .active_pwr(active_pwr),
      .mode_oh(mode_oh), .sts(sts), .cfg(cfg), .rd_mode(rd_mode));

   always @(posedge clk) begin
      if (!rst_n) ec <= 0;
      else        ec <= ec + 1;
   end
   always @(negedge clk) if (wr_accept) acc_cnt <= acc_cnt + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_to(input int n);
      while (ec != n) @(negedge clk);
   endtask

   task automatic enter_reset();
      @(negedge clk);
      rst_n = 1'b0; we_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic release_reset();
      rst_n = 1'b1;
      acc_cnt = 0;
   endtask

   task automatic t_reset_defaults();
      ce_n = 1'b0; oe_n = 1'b0;
      enter_reset();
      chk(dq_oe == 1'b0, "R2 dq_oe in reset", dq_oe, 0);
      chk(mode_oh == 5'b00001, "R2 mode in reset", mode_oh, 5'b00001);
      chk(sts == 8'h80, "R5 status default", sts, 8'h80);
      chk(cfg == 16'h0000, "R5 config default", cfg, 0);
      chk(rd_mode == 2'd0, "R5 read-array default", rd_mode, 0);
      chk(eng_abort == 1'b0, "R6 no abort when idle", eng_abort, 0);
   endtask

   task automatic t_wake_windows();
      release_reset();
      wait_to(100); we_n = 1'b0;
      wait_to(101); we_n = 1'b1;
      wait_to(103);
      chk(wr_rej == 1'b1, "R4 early write flagged", wr_rej, 1);
      chk(acc_cnt == 0, "R4 early write not accepted", acc_cnt, 0);
      wait_to(T_OV - 1);
      chk(dq_oe == 1'b0, "R3 no drive before output-valid", dq_oe, 0);
      chk(mode_oh == 5'b00010, "R9 wakeup mode", mode_oh, 5'b00010);
      wait_to(T_OV);
      chk(dq_oe == 1'b1, "R3 drive at output-valid", dq_oe, 1);
      wait_to(T_WE - 1);
      chk(mode_oh == 5'b00010, "R9 still wakeup", mode_oh, 5'b00010);
      wait_to(T_WE);
      chk(mode_oh == 5'b01000, "R9 active idle after wakeup", mode_oh, 5'b01000);
      chk(active_pwr == 1'b1, "R9 active power idle", active_pwr, 1);
   endtask

   task automatic t_write_edge_reject();
      enter_reset();
      release_reset();
      wait_to(T_WE - 2); we_n = 1'b0;
      wait_to(T_WE - 1); we_n = 1'b1;
      wait_to(T_WE + 1);
      chk(wr_rej == 1'b1, "R4 strobe at last closed edge rejected", wr_rej, 1);
      chk(acc_cnt == 0, "R4 strobe at last closed edge not accepted", acc_cnt, 0);
      we_n = 1'b0;
      wait_to(T_WE + 2); we_n = 1'b1;
      wait_to(T_WE + 4);
      chk(acc_cnt == 1, "R4 later write accepted", acc_cnt, 1);
      chk(wr_rej == 1'b1, "R10 reject flag survives accepted write", wr_rej, 1);
   endtask

   task automatic t_write_edge_accept();
      enter_reset();
      chk(wr_rej == 1'b0, "R10 reset clears reject flag", wr_rej, 0);
      release_reset();
      wait_to(T_WE - 1); we_n = 1'b0;
      wait_to(T_WE);     we_n = 1'b1;
      wait_to(T_WE + 1);
      chk(wr_accept == 1'b1, "R4 strobe at first open edge accepted", wr_accept, 1);
      chk(wr_rej == 1'b0, "R4 no reject at first open edge", wr_rej, 0);
      wait_to(T_WE + 2);
      chk(wr_accept == 1'b0, "R4 accept is one cycle", wr_accept, 0);
   endtask

   task automatic t_standby();
      ce_n = 1'b1; oe_n = 1'b0;
      @(negedge clk);
      chk(mode_oh == 5'b00100, "R9 standby", mode_oh, 5'b00100);
      chk(dq_oe == 1'b0, "R1 hi-z when deselected", dq_oe, 0);
      chk(active_pwr == 1'b0, "R9 no active power in standby", active_pwr, 0);
      ce_n = 1'b0; oe_n = 1'b1;
      #1;
      chk(dq_oe == 1'b0, "R1 hi-z without output enable", dq_oe, 0);
      @(negedge clk);
      chk(mode_oh == 5'b01000, "R9 active idle on select", mode_oh, 5'b01000);
   endtask

   task automatic t_busy_deselect();
      eng_busy = 1'b1;
      #1;
      chk(sts == 8'h00, "R7 busy status", sts, 8'h00);
      @(negedge clk);
      chk(mode_oh == 5'b10000, "R8 busy mode", mode_oh, 5'b10000);
      ce_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(mode_oh == 5'b10000, "R8 busy survives deselect", mode_oh, 5'b10000);
      chk(active_pwr == 1'b1, "R8 active power while deselected", active_pwr, 1);
      eng_busy = 1'b0;
      #1;
      chk(sts == 8'h80, "R7 idle status", sts, 8'h80);
      @(negedge clk);
      chk(mode_oh == 5'b00100, "R8 standby after completion", mode_oh, 5'b00100);
      chk(active_pwr == 1'b0, "R8 active power drops", active_pwr, 0);
   endtask

   task automatic t_abort();
      ce_n = 1'b0; eng_busy = 1'b1;
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(eng_abort == 1'b1, "R6 abort with reset", eng_abort, 1);
      chk(dq_oe == 1'b0, "R2 hi-z at reset", dq_oe, 0);
      @(negedge clk);
      eng_busy = 1'b0;
      repeat (2) @(negedge clk);
      release_reset();
      wait_to(T_WE);
      chk(sts == 8'hA0, "R6 invalid mark after abort", sts, 8'hA0);
      we_n = 1'b0;
      wait_to(T_WE + 1); we_n = 1'b1;
      wait_to(T_WE + 2);
      chk(wr_accept == 1'b1, "R6 clearing write accepted", wr_accept, 1);
      wait_to(T_WE + 3);
      chk(sts == 8'h80, "R6 mark cleared by accepted write", sts, 8'h80);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      t_reset_defaults();
      t_wake_windows();
      t_write_edge_reject();
      t_write_edge_accept();
      t_standby();
      t_busy_deselect();
      t_abort();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule